// File: doc/BRIEF.md
# DRAM Row-Buffer Hit Tracker

This block keeps a model of the row buffers in a DRAM with one channel, one rank and a power-of-two number of banks. It stores no data. Each incoming byte address is split into a bank index and a row index, using one of two address maps chosen when the block is built. The block then decides whether the access finds its row already open in that bank. The policy is open-row: an accessed row stays in its bank's buffer until another row of the same bank is touched.

For every accepted request, a registered result appears on the next cycle. It carries the hit flag, the bank and the row. Two saturating counters accumulate hits and misses so that a hit rate can be read for any request stream. A synchronous clear input zeroes both counters without disturbing the open-row state.

The block is meant for address-pattern studies and for a performance monitor that sits beside a memory controller. The caller sets the map, the bank count, the block and row sizes and the row that every bank holds open after reset.

Top module: `rowbuf_tracker`

## Requirements
- R1: After reset, resValid is 0, both counters are 0, and every bank holds the row given by INIT_ROW, so the first access to a bank is a hit only when its row equals INIT_ROW.
- R2: In block-interleaved mode with the defaults (32-byte blocks, 128-byte rows, 4 banks, 12-bit address), the bank is address bits [6:5] and the row is address bits [11:9]: consecutive blocks go to consecutive banks.
- R3: A request is a hit when its row equals the open row of its bank. Otherwise it is a miss, and that bank's open row becomes the requested row.
- R4: A request accepted on a clock edge (reqValid high) yields resValid high with its hit flag, bank and row right after that edge. Requests may arrive back to back, one per cycle.
- R5: A request changes the open row of its own bank only. Rows held in other banks are unaffected.
- R6: Each accepted request adds exactly one to hitCnt (when it hits) or to missCnt (when it misses).
- R7: Each counter is 16 bits wide and stops at 65535 instead of wrapping.
- R8: A high clearCnt zeroes both counters on the next edge. When a request arrives in the same cycle, the clear wins, so that request is not counted. The request still updates the open row and is still reported.
- R9: With reqValid low, resValid is 0 on the next cycle. The counters and the open rows do not change, whatever the value on reqAddr.
- R10: In row-interleaved mode with 64-byte blocks and 256-byte rows (4 banks), the bank is address bits [9:8] and the row is the address shifted right by 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | ADDR_W | Byte address of the request |
| clearCnt | input | 1 | Synchronous clear of both counters |
| resValid | output | 1 | Result strobe, one cycle after a request |
| resHit | output | 1 | 1 = row-buffer hit, 0 = miss |
| resBank | output | log2(NUM_BANKS) | Decoded bank of the request |
| resRow | output | ROW_W | Decoded row of the request |
| hitCnt | output | CNT_W | Saturating hit count |
| missCnt | output | CNT_W | Saturating miss count |

## Verification
Counter clearing and request counting can land in the same cycle, because clearCnt and reqValid are independent inputs. The bench first drives the hit counter into saturation. It then raises clearCnt together with a request that must miss. The next cycle must show both counters at zero while the result still reports the miss with its bank and row. A following request to the same address must then hit, which confirms that the clear left the row state intact.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;

  typedef enum logic {
    MAP_BLOCK = 1'b0,
    MAP_ROW   = 1'b1
  } mapMode_e;

  typedef struct packed {
    logic takeReq;
    logic rowHit;
    logic incHit;
    logic incMiss;
    logic clearCnt;
  } ctrlStrobes_t;

endpackage

// File: rtl/rowbuf_addr_map.sv
module rowbuf_addr_map #(
  parameter rowbuf_pkg::mapMode_e MAP_MODE = rowbuf_pkg::MAP_BLOCK,
  parameter int ADDR_W      = 12,
  parameter int NUM_BANKS   = 4,
  parameter int BLOCK_BYTES = 32,
  parameter int ROW_BYTES   = 128,
  parameter int ROW_W       = 11,
  localparam int BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row
);
  localparam int BLK_OFF     = $clog2(BLOCK_BYTES);
  localparam int ROW_OFF     = $clog2(ROW_BYTES);
  localparam int BLKS_PER_RW = ROW_BYTES / BLOCK_BYTES;
  localparam int COL_W       = $clog2(BLKS_PER_RW);

  generate
    if (MAP_MODE == rowbuf_pkg::MAP_BLOCK) begin : g_blockMap
      localparam int ROW_SHIFT = BLK_OFF + BANK_W + COL_W;
      // low block-number bits select the bank; the rest is split into column and row
      assign bank = addr[BLK_OFF +: BANK_W];
      assign row  = ROW_W'(addr >> ROW_SHIFT);
    end else begin : g_rowMap
      localparam int ROW_SHIFT = ROW_OFF + BANK_W;
      // row | bank | column | byte offset, from high to low
      assign bank = addr[ROW_OFF +: BANK_W];
      assign row  = ROW_W'(addr >> ROW_SHIFT);
    end
  endgenerate

endmodule

// File: rtl/rowbuf_ctrl.sv
module rowbuf_ctrl #(
  parameter int ROW_W = 11
) (
  input  logic                     reqValid,
  input  logic                     clearCnt,
  input  logic [ROW_W-1:0]         reqRow,
  input  logic [ROW_W-1:0]         curOpenRow,
  output rowbuf_pkg::ctrlStrobes_t strb
);
  logic isHit;

  always_comb begin
    isHit         = (reqRow == curOpenRow);
    strb.takeReq  = reqValid;
    strb.rowHit   = reqValid && isHit;
    strb.clearCnt = clearCnt;
    // a clear in the same cycle suppresses counting of the request
    strb.incHit   = reqValid && isHit && !clearCnt;
    strb.incMiss  = reqValid && !isHit && !clearCnt;
  end

endmodule

// File: rtl/rowbuf_datapath.sv
module rowbuf_datapath #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 11,
  parameter int CNT_W     = 16,
  parameter int INIT_ROW  = 1024,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  rowbuf_pkg::ctrlStrobes_t strb,
  input  logic [BANK_W-1:0]        reqBank,
  input  logic [ROW_W-1:0]         reqRow,
  output logic [ROW_W-1:0]         curOpenRow,
  output logic                     resValid,
  output logic                     resHit,
  output logic [BANK_W-1:0]        resBank,
  output logic [ROW_W-1:0]         resRow,
  output logic [CNT_W-1:0]         hitCnt,
  output logic [CNT_W-1:0]         missCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [ROW_W-1:0] openRow [NUM_BANKS];

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [ROW_W-1:0] rowReg;
      always_ff @(posedge clk) begin
        if (rst)
          rowReg <= ROW_W'(INIT_ROW);
        else if (strb.takeReq && !strb.rowHit && reqBank == BANK_W'(b))
          rowReg <= reqRow;
      end
      assign openRow[b] = rowReg;
    end
  endgenerate

  assign curOpenRow = openRow[reqBank];

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid <= 1'b0;
      resHit   <= 1'b0;
      resBank  <= '0;
      resRow   <= '0;
    end else begin
      resValid <= strb.takeReq;
      if (strb.takeReq) begin
        resHit  <= strb.rowHit;
        resBank <= reqBank;
        resRow  <= reqRow;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clearCnt) begin
      hitCnt  <= '0;
      missCnt <= '0;
    end else begin
      if (strb.incHit && hitCnt != CNT_MAX)
        hitCnt <= hitCnt + 1'b1;
      if (strb.incMiss && missCnt != CNT_MAX)
        missCnt <= missCnt + 1'b1;
    end
  end

  // R3: the reported row is now the open row of the reported bank
  assert_open_row_R3: assert property (@(posedge clk) disable iff (rst)
    resValid |-> openRow[resBank] == resRow);

  // R6: never both counters move in one cycle
  assert_one_count_R6: assert property (@(posedge clk) disable iff (rst)
    !strb.clearCnt |=> ($stable(hitCnt) || $stable(missCnt)));

  // R7: a full counter stays full
  assert_hit_sat_R7: assert property (@(posedge clk) disable iff (rst)
    (hitCnt == CNT_MAX && !strb.clearCnt) |=> hitCnt == CNT_MAX);
  assert_miss_sat_R7: assert property (@(posedge clk) disable iff (rst)
    (missCnt == CNT_MAX && !strb.clearCnt) |=> missCnt == CNT_MAX);

  // R8: clear empties both counters
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    strb.clearCnt |=> (hitCnt == '0 && missCnt == '0));

endmodule

// File: rtl/rowbuf_tracker.sv
module rowbuf_tracker #(
  parameter rowbuf_pkg::mapMode_e MAP_MODE = rowbuf_pkg::MAP_BLOCK,
  parameter int ADDR_W      = 12,
  parameter int NUM_BANKS   = 4,
  parameter int BLOCK_BYTES = 32,
  parameter int ROW_BYTES   = 128,
  parameter int ROW_W       = 11,
  parameter int INIT_ROW    = 1024,
  parameter int CNT_W       = 16,
  localparam int BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              clearCnt,
  output logic              resValid,
  output logic              resHit,
  output logic [BANK_W-1:0] resBank,
  output logic [ROW_W-1:0]  resRow,
  output logic [CNT_W-1:0]  hitCnt,
  output logic [CNT_W-1:0]  missCnt
);
  logic [BANK_W-1:0]        reqBank;
  logic [ROW_W-1:0]         reqRow;
  logic [ROW_W-1:0]         curOpenRow;
  rowbuf_pkg::ctrlStrobes_t strb;

  rowbuf_addr_map #(
    .MAP_MODE(MAP_MODE), .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS),
    .BLOCK_BYTES(BLOCK_BYTES), .ROW_BYTES(ROW_BYTES), .ROW_W(ROW_W)
  ) i_addrMap (
    .addr(reqAddr), .bank(reqBank), .row(reqRow)
  );

  rowbuf_ctrl #(.ROW_W(ROW_W)) i_ctrl (
    .reqValid(reqValid), .clearCnt(clearCnt), .reqRow(reqRow),
    .curOpenRow(curOpenRow), .strb(strb)
  );

  rowbuf_datapath #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .CNT_W(CNT_W), .INIT_ROW(INIT_ROW)
  ) i_datapath (
    .clk(clk), .rst(rst), .strb(strb), .reqBank(reqBank), .reqRow(reqRow),
    .curOpenRow(curOpenRow), .resValid(resValid), .resHit(resHit),
    .resBank(resBank), .resRow(resRow), .hitCnt(hitCnt), .missCnt(missCnt)
  );

  // R4: every accepted request is answered on the next cycle
  assert_res_latency_R4: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> resValid);

  // R9: no request, no result
  assert_no_res_R9: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !resValid);

endmodule

// File: tb/test_rowbuf_tracker.sv
`timescale 1ns/1ps
module test_rowbuf_tracker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // block-interleaved instance (defaults)
  logic        reqValid = 1'b0, clearCnt = 1'b0;
  logic [11:0] reqAddr = '0;
  logic        resValid, resHit;
  logic [1:0]  resBank;
  logic [10:0] resRow;
  logic [15:0] hitCnt, missCnt;

  rowbuf_tracker i_rowbuf_tracker (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .clearCnt(clearCnt), .resValid(resValid), .resHit(resHit),
    .resBank(resBank), .resRow(resRow), .hitCnt(hitCnt), .missCnt(missCnt)
  );

  // row-interleaved instance, every bank starts on row 0
  logic        rValid = 1'b0, rClear = 1'b0;
  logic [11:0] rAddr = '0;
  logic        rResValid, rResHit;
  logic [1:0]  rResBank;
  logic [10:0] rResRow;
  logic [15:0] rHitCnt, rMissCnt;

  rowbuf_tracker #(
    .MAP_MODE(rowbuf_pkg::MAP_ROW), .BLOCK_BYTES(64), .ROW_BYTES(256), .INIT_ROW(0)
  ) i_rowbuf_tracker_rowMap (
    .clk(clk), .rst(rst), .reqValid(rValid), .reqAddr(rAddr),
    .clearCnt(rClear), .resValid(rResValid), .resHit(rResHit),
    .resBank(rResBank), .resRow(rResRow), .hitCnt(rHitCnt), .missCnt(rMissCnt)
  );

  typedef struct packed {
    logic [11:0] a;
    logic        h;
    logic [1:0]  b;
    logic [10:0] r;
  } vec_t;

  // R2 R3 R5: block map, bank = addr[6:5], row = addr[11:9]
  localparam int NVEC = 22;
  localparam vec_t VECS [NVEC] = '{
    '{12'd0,    1'b0, 2'd0, 11'd0}, '{12'd32,   1'b0, 2'd1, 11'd0},
    '{12'd320,  1'b0, 2'd2, 11'd0}, '{12'd480,  1'b0, 2'd3, 11'd0},
    '{12'd4,    1'b1, 2'd0, 11'd0}, '{12'd36,   1'b1, 2'd1, 11'd0},
    '{12'd324,  1'b1, 2'd2, 11'd0}, '{12'd484,  1'b1, 2'd3, 11'd0},
    '{12'd8,    1'b1, 2'd0, 11'd0}, '{12'd40,   1'b1, 2'd1, 11'd0},
    '{12'd328,  1'b1, 2'd2, 11'd0}, '{12'd488,  1'b1, 2'd3, 11'd0},
    '{12'd12,   1'b1, 2'd0, 11'd0}, '{12'd44,   1'b1, 2'd1, 11'd0},
    '{12'd332,  1'b1, 2'd2, 11'd0}, '{12'd492,  1'b1, 2'd3, 11'd0},
    '{12'd512,  1'b0, 2'd0, 11'd1}, '{12'd0,    1'b0, 2'd0, 11'd0},
    '{12'd4000, 1'b0, 2'd1, 11'd7}, '{12'd36,   1'b0, 2'd1, 11'd0},
    '{12'd4064, 1'b0, 2'd3, 11'd7}, '{12'd4064, 1'b1, 2'd3, 11'd7}
  };

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReq(input logic [11:0] a);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doRowReq(input logic [11:0] a, input logic h, input logic [1:0] b,
                          input logic [10:0] r);
    @(negedge clk);
    rValid = 1'b1; rAddr = a;
    @(negedge clk);
    rValid = 1'b0;
    check("R10 valid", rResValid, 1);
    check("R10 hit", rResHit, h);
    check("R10 bank", rResBank, b);
    check("R10 row", rResRow, r);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 resValid", resValid, 0);
    check("R1 hitCnt", hitCnt, 0);
    check("R1 missCnt", missCnt, 0);

    // R10 and R1 (INIT_ROW = 0 gives hits on row 0 from the start)
    doRowReq(12'd0,    1'b1, 2'd0, 11'd0);
    doRowReq(12'd64,   1'b1, 2'd0, 11'd0);
    doRowReq(12'd256,  1'b1, 2'd1, 11'd0);
    doRowReq(12'd1024, 1'b0, 2'd0, 11'd1);
    doRowReq(12'd0,    1'b0, 2'd0, 11'd0);
    doRowReq(12'd192,  1'b1, 2'd0, 11'd0);
    doRowReq(12'd768,  1'b1, 2'd3, 11'd0);
    check("R10 hitCnt", rHitCnt, 5);
    check("R10 missCnt", rMissCnt, 2);

    // table walk: R2 R3 R4 R5, first touches miss against INIT_ROW 1024 (R1)
    for (int i = 0; i < NVEC; i++) begin
      doReq(VECS[i].a);
      check("R4 resValid", resValid, 1);
      check("R3 hit", resHit, VECS[i].h);
      check("R2 bank", resBank, VECS[i].b);
      check("R2 row", resRow, VECS[i].r);
    end
    check("R6 hitCnt", hitCnt, 13);
    check("R6 missCnt", missCnt, 9);

    // R9: idle cycles with a foreign address on the bus
    @(negedge clk);
    reqAddr = 12'd512;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 resValid", resValid, 0);
      check("R9 hitCnt", hitCnt, 13);
      check("R9 missCnt", missCnt, 9);
    end
    doReq(12'd0);
    check("R9 row kept", resHit, 1);
    check("R6 hitCnt", hitCnt, 14);

    // R8 clear alone
    @(negedge clk);
    clearCnt = 1'b1;
    @(negedge clk);
    clearCnt = 1'b0;
    check("R8 hitCnt", hitCnt, 0);
    check("R8 missCnt", missCnt, 0);

    // R7 saturation with back-to-back hits (R4)
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 12'd0;
    repeat (65536) @(negedge clk);
    reqValid = 1'b0;
    check("R4 streaming valid", resValid, 1);
    check("R7 hitCnt", hitCnt, 65535);
    check("R7 missCnt", missCnt, 0);
    doReq(12'd512);
    check("R7 miss", resHit, 0);
    check("R7 hitCnt held", hitCnt, 65535);
    check("R7 missCnt", missCnt, 1);

    // R8 clear together with a miss request
    @(negedge clk);
    clearCnt = 1'b1; reqValid = 1'b1; reqAddr = 12'd0;
    @(negedge clk);
    clearCnt = 1'b0; reqValid = 1'b0;
    check("R8 result valid", resValid, 1);
    check("R8 result hit", resHit, 0);
    check("R8 result row", resRow, 0);
    check("R8 hitCnt", hitCnt, 0);
    check("R8 missCnt", missCnt, 0);
    doReq(12'd4);
    check("R8 row updated", resHit, 1);
    check("R8 hitCnt after", hitCnt, 1);
    check("R8 missCnt after", missCnt, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule